// File: doc/BRIEF.md
# Kernel Launch Register Window

This block sits behind a small memory-mapped window and lets a host set up and start a compute kernel. The host first fills a task descriptor a few bytes at a time, then writes the control word at the bottom of the window. That write starts the launch. At that moment the block turns the descriptor's grid and workgroup sizes into a three-dimensional workgroup count and a total. It gives the kernel the next sequential identifier and pushes the identifier into a small pending queue. A downstream workgroup dispatcher drains that queue.

Reads of the control word report whether any launched kernel is still waiting for dispatch. Every access, read or write, legal or not, is answered after the same fixed number of cycles. Only one access is in flight at a time. An illegal access gets an error response and changes no state.

The descriptor occupies `DESC_BYTES` bytes placed 8 bytes above the window base. Its first six `DIM_W`-bit fields carry the sizes in little-endian order: grid X, Y and Z, then workgroup X, Y and Z. The remaining descriptor bytes are free storage that is copied out with the launch record.

Top module: `kl_regwin`

## Requirements
- R1: An access whose address lies outside the 4096-byte window starting at `BASE` is answered with `rsp_err`=1 and `rsp_rdata`=0, and it changes no state.
- R2: A read of window offset 0 with size code 3 (8 bytes) returns the dispatch-active flag in bit 0 and zeros in all other bits. A read of offset 0 with any other size is answered with an error.
- R3: `req_size` encodes the access width as 0=1, 1=2, 2=4 and 3=8 bytes. Descriptor byte i sits at window offset 8+i. Write data and read data are little-endian, starting at lane 0 (bits 7:0), and unused read lanes return 0.
- R4: An access that touches window offsets 1 to 7, or that runs past the last descriptor byte, is answered with an error and writes nothing.
- R5: A legal write of any size to offset 0 produces `launch_valid` for exactly one cycle, in the cycle after the request is accepted. The launch record carries the whole descriptor on `launch_desc`, with byte i at bits 8i+7:8i.
- R6: For each dimension, the launch reports ceil(grid/workgroup) workgroups. `launch_wg_total` is the product of the three counts, and a zero grid size yields a count of 0.
- R7: Kernel identifiers start at 0 after reset and increase by one on each accepted launch only.
- R8: Each launched identifier enters a FIFO of depth `QDEPTH`. The head appears on `pq_id` while `pq_valid`=1, and `pq_pop` removes it.
- R9: The dispatch-active flag is set by a launch and cleared when the pending queue is drained.
- R10: A launch raises `tick_req`. It stays high, once, across further launches until a cycle with `tick_ack` and no launch.
- R11: A launch whose descriptor has any zero workgroup size, or that finds the pending queue full, is answered with an error. It consumes no identifier, pushes nothing and produces no `launch_valid`.
- R12: A response arrives exactly `RSP_LAT` cycles after acceptance, and `req_ready` stays low until it has been delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_size | input | 2 | Access width code |
| req_wdata | input | 64 | Write data, lane 0 first |
| rsp_valid | output | 1 | Response strobe |
| rsp_rdata | output | 64 | Read data |
| rsp_err | output | 1 | Access was rejected |
| launch_valid | output | 1 | Launch record valid |
| launch_id | output | ID_W | Identifier given to the kernel |
| launch_wg_x | output | DIM_W | Workgroups along X |
| launch_wg_y | output | DIM_W | Workgroups along Y |
| launch_wg_z | output | DIM_W | Workgroups along Z |
| launch_wg_total | output | 3*DIM_W | Total workgroups |
| launch_desc | output | 8*DESC_BYTES | Descriptor copy |
| pq_valid | output | 1 | Pending queue not empty |
| pq_id | output | ID_W | Identifier at queue head |
| pq_pop | input | 1 | Remove queue head |
| tick_req | output | 1 | Dispatch tick requested |
| tick_ack | input | 1 | Tick request consumed |

## Verification
On every cycle the assertions check four things. Each accepted launch's count per dimension brackets the true quotient from above. The active flag always agrees with queue occupancy. A launch pulse always comes with a tick request. A rejected launch or an overflowing push never reaches the queue. The scenarios are needed for the behaviour that depends on stored history or data values. These are byte placement and little-endian read-back, window and descriptor boundaries, identifier sequence and queue order across rejections, tick hold and release, and the exact response latency.

// File: rtl/kl_pkg.sv
package kl_pkg;
  typedef enum logic [1:0] {
    SZ_1B = 2'd0,
    SZ_2B = 2'd1,
    SZ_4B = 2'd2,
    SZ_8B = 2'd3
  } acc_size_e;

  localparam int unsigned WIN_BYTES  = 4096;
  localparam int unsigned CTRL_BYTES = 8;
  localparam int unsigned NDIM       = 3;
endpackage

// File: rtl/kl_decode.sv
module kl_decode
  import kl_pkg::*;
#(
  parameter int              ADDR_W     = 32,
  parameter logic [ADDR_W-1:0] BASE     = '0,
  parameter int              DESC_BYTES = 32
) (
  input  logic [ADDR_W-1:0]             addr_i,
  input  acc_size_e                     size_i,
  input  logic                          write_i,
  output logic                          ctrl_hit_o,
  output logic                          desc_hit_o,
  output logic [$clog2(DESC_BYTES)-1:0] doff_o,
  output logic [3:0]                    nbytes_o
);
  localparam int DOFF_W = $clog2(DESC_BYTES);

  logic [ADDR_W-1:0] rel;
  logic [ADDR_W-1:0] drel;
  logic              in_win;

  always_comb begin
    rel        = addr_i - BASE;
    in_win     = (addr_i >= BASE) && (rel < ADDR_W'(WIN_BYTES));
    nbytes_o   = 4'd1 << size_i;
    drel       = rel - ADDR_W'(CTRL_BYTES);
    // offset 0: writes of any width launch, reads must be full width
    ctrl_hit_o = in_win && (rel == '0) && (write_i || (size_i == SZ_8B));
    desc_hit_o = in_win && (rel >= ADDR_W'(CTRL_BYTES)) &&
                 ((drel + ADDR_W'(nbytes_o)) <= ADDR_W'(DESC_BYTES));
    doff_o     = drel[DOFF_W-1:0];
  end
endmodule

// File: rtl/kl_grid.sv
module kl_grid #(
  parameter int DIM_W = 16
) (
  input  logic [2:0][DIM_W-1:0] grid_i,
  input  logic [2:0][DIM_W-1:0] wgsz_i,
  output logic [2:0][DIM_W-1:0] cnt_o,
  output logic [3*DIM_W-1:0]    total_o,
  output logic                  zero_o
);
  localparam int TOT_W = 3 * DIM_W;

  logic [2:0] zdim;

  for (genvar d = 0; d < 3; d++) begin : g_dim
    logic [DIM_W:0] den;
    logic [DIM_W:0] num;
    assign den       = {1'b0, wgsz_i[d]};
    assign num       = {1'b0, grid_i[d]} + den - (DIM_W+1)'(1);
    assign zdim[d]   = (wgsz_i[d] == '0);
    assign cnt_o[d]  = zdim[d] ? '0 : DIM_W'(num / den);
  end

  assign total_o = TOT_W'(cnt_o[0]) * TOT_W'(cnt_o[1]) * TOT_W'(cnt_o[2]);
  assign zero_o  = |zdim;
endmodule

// File: rtl/kl_pend_fifo.sv
module kl_pend_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic         valid_o,
  output logic [W-1:0] data_o,
  output logic         full_o,
  output logic         last_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] rd_q, rd_d, wr_q, wr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          push_eff, pop_eff;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_comb begin
    push_eff = push_i && !full_o;
    pop_eff  = pop_i && valid_o;
    rd_d     = pop_eff  ? step(rd_q) : rd_q;
    wr_d     = push_eff ? step(wr_q) : wr_q;
    cnt_d    = cnt_q + CW'(push_eff) - CW'(pop_eff);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      rd_q  <= rd_d;
      wr_q  <= wr_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_eff) mem_q[wr_q] <= data_i;
  end

  assign valid_o = (cnt_q != '0);
  assign data_o  = mem_q[rd_q];
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign last_o  = (cnt_q == CW'(1));

  // R11: the launch logic must never push into a full queue
  assert_no_overflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
    push_i |-> !full_o);
endmodule

// File: rtl/kl_regwin.sv
module kl_regwin
  import kl_pkg::*;
#(
  parameter int                ADDR_W     = 32,
  parameter logic [ADDR_W-1:0] BASE       = 32'h0000_4000,
  parameter int                DESC_BYTES = 32,
  parameter int                DIM_W      = 16,
  parameter int                ID_W       = 8,
  parameter int                QDEPTH     = 4,
  parameter int                RSP_LAT    = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic                    req_write,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic [1:0]              req_size,
  input  logic [63:0]             req_wdata,
  output logic                    rsp_valid,
  output logic [63:0]             rsp_rdata,
  output logic                    rsp_err,
  output logic                    launch_valid,
  output logic [ID_W-1:0]         launch_id,
  output logic [DIM_W-1:0]        launch_wg_x,
  output logic [DIM_W-1:0]        launch_wg_y,
  output logic [DIM_W-1:0]        launch_wg_z,
  output logic [3*DIM_W-1:0]      launch_wg_total,
  output logic [8*DESC_BYTES-1:0] launch_desc,
  output logic                    pq_valid,
  output logic [ID_W-1:0]         pq_id,
  input  logic                    pq_pop,
  output logic                    tick_req,
  input  logic                    tick_ack
);
  localparam int DOFF_W    = $clog2(DESC_BYTES);
  localparam int DIM_BYTES = DIM_W / 8;
  localparam int TOT_W     = 3 * DIM_W;
  localparam int PW2       = 2 * DIM_W;

  // ---------------- reset release synchroniser ----------------
  logic [1:0] rs_q;
  logic       rst_nq;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_nq = rs_q[1];

  // ---------------- decode ----------------
  logic              ctrl_hit, desc_hit;
  logic [DOFF_W-1:0] doff;
  logic [3:0]        nbytes;
  acc_size_e         size_e;
  assign size_e = acc_size_e'(req_size);

  kl_decode #(.ADDR_W(ADDR_W), .BASE(BASE), .DESC_BYTES(DESC_BYTES)) u_dec (
    .addr_i(req_addr), .size_i(size_e), .write_i(req_write),
    .ctrl_hit_o(ctrl_hit), .desc_hit_o(desc_hit), .doff_o(doff), .nbytes_o(nbytes)
  );

  // ---------------- descriptor storage ----------------
  logic [7:0]              desc_q [DESC_BYTES];
  logic [7:0]              desc_d [DESC_BYTES];
  logic [8*DESC_BYTES-1:0] desc_flat;
  logic [2:0][DIM_W-1:0]   grid_f, wg_f, cnt_w;
  logic [TOT_W-1:0]        tot_w;
  logic                    zero_wg;

  logic accept, wr_desc, launch_ok, acc_err, q_full, q_last;
  logic active_q, active_d, tick_q, tick_d;
  logic [ID_W-1:0] id_q, id_d;

  assign accept  = req_valid && req_ready;
  assign wr_desc = accept && req_write && desc_hit;

  always_comb begin
    for (int j = 0; j < DESC_BYTES; j++) desc_d[j] = desc_q[j];
    for (int k = 0; k < 8; k++) begin
      if (k < int'(nbytes)) desc_d[doff + DOFF_W'(k)] = req_wdata[8*k +: 8];
    end
  end

  always_ff @(posedge clk or negedge rst_nq) begin
    if (!rst_nq) begin
      for (int j = 0; j < DESC_BYTES; j++) desc_q[j] <= '0;
    end else if (wr_desc) begin
      for (int j = 0; j < DESC_BYTES; j++) desc_q[j] <= desc_d[j];
    end
  end

  always_comb begin
    for (int j = 0; j < DESC_BYTES; j++) desc_flat[8*j +: 8] = desc_q[j];
    for (int d = 0; d < 3; d++) begin
      for (int b = 0; b < DIM_BYTES; b++) begin
        grid_f[d][8*b +: 8] = desc_q[d*DIM_BYTES + b];
        wg_f[d][8*b +: 8]   = desc_q[(3+d)*DIM_BYTES + b];
      end
    end
  end

  kl_grid #(.DIM_W(DIM_W)) u_grid (
    .grid_i(grid_f), .wgsz_i(wg_f), .cnt_o(cnt_w), .total_o(tot_w), .zero_o(zero_wg)
  );

  // ---------------- launch control ----------------
  assign launch_ok = accept && req_write && ctrl_hit && !zero_wg && !q_full;
  assign acc_err   = accept && (!(ctrl_hit || desc_hit) ||
                                (req_write && ctrl_hit && !launch_ok));

  kl_pend_fifo #(.W(ID_W), .DEPTH(QDEPTH)) u_q (
    .clk(clk), .rst_n(rst_nq), .push_i(launch_ok), .data_i(id_q), .pop_i(pq_pop),
    .valid_o(pq_valid), .data_o(pq_id), .full_o(q_full), .last_o(q_last)
  );

  always_comb begin
    id_d     = launch_ok ? id_q + ID_W'(1) : id_q;
    active_d = launch_ok || (active_q && !(pq_pop && pq_valid && q_last));
    tick_d   = launch_ok || (tick_q && !tick_ack);
  end

  logic                    lv_q;
  logic [ID_W-1:0]         lid_q;
  logic [2:0][DIM_W-1:0]   lcnt_q;
  logic [TOT_W-1:0]        ltot_q;
  logic [8*DESC_BYTES-1:0] ldesc_q;

  always_ff @(posedge clk or negedge rst_nq) begin
    if (!rst_nq) begin
      id_q     <= '0;
      active_q <= 1'b0;
      tick_q   <= 1'b0;
      lv_q     <= 1'b0;
      lid_q    <= '0;
      lcnt_q   <= '0;
      ltot_q   <= '0;
      ldesc_q  <= '0;
    end else begin
      id_q     <= id_d;
      active_q <= active_d;
      tick_q   <= tick_d;
      lv_q     <= launch_ok;
      if (launch_ok) begin
        lid_q   <= id_q;
        lcnt_q  <= cnt_w;
        ltot_q  <= tot_w;
        ldesc_q <= desc_flat;
      end
    end
  end

  // ---------------- read data and response pipe ----------------
  logic [63:0]        rd_data;
  logic [RSP_LAT-1:0] pv_q, pv_d, pe_q, pe_d;
  logic [63:0]        pd_q [RSP_LAT];

  always_comb begin
    rd_data = '0;
    if (!req_write) begin
      if (ctrl_hit) rd_data[0] = active_q;
      else if (desc_hit) begin
        for (int k = 0; k < 8; k++) begin
          if (k < int'(nbytes)) rd_data[8*k +: 8] = desc_q[doff + DOFF_W'(k)];
        end
      end
    end
  end

  always_comb begin
    pv_d[0] = accept;
    pe_d[0] = acc_err;
    for (int k = 1; k < RSP_LAT; k++) begin
      pv_d[k] = pv_q[k-1];
      pe_d[k] = pe_q[k-1];
    end
  end

  always_ff @(posedge clk or negedge rst_nq) begin
    if (!rst_nq) begin
      pv_q <= '0;
      pe_q <= '0;
    end else begin
      pv_q <= pv_d;
      pe_q <= pe_d;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) pd_q[0] <= rd_data;
    for (int k = 1; k < RSP_LAT; k++) begin
      if (pv_q[k-1]) pd_q[k] <= pd_q[k-1];
    end
  end

  assign req_ready       = rst_nq && (pv_q == '0);
  assign rsp_valid       = pv_q[RSP_LAT-1];
  assign rsp_err         = pe_q[RSP_LAT-1];
  assign rsp_rdata       = pd_q[RSP_LAT-1];
  assign launch_valid    = lv_q;
  assign launch_id       = lid_q;
  assign launch_wg_x     = lcnt_q[0];
  assign launch_wg_y     = lcnt_q[1];
  assign launch_wg_z     = lcnt_q[2];
  assign launch_wg_total = ltot_q;
  assign launch_desc     = ldesc_q;
  assign tick_req        = tick_q;

  // ---------------- assertions ----------------
  assert_busy_R12: assert property (@(posedge clk) disable iff (!rst_nq)
    accept |=> !req_ready);

  assert_active_queue_R9: assert property (@(posedge clk) disable iff (!rst_nq)
    active_q == pq_valid);

  assert_pulse_R5: assert property (@(posedge clk) disable iff (!rst_nq)
    launch_valid |=> !launch_valid);

  assert_tick_R10: assert property (@(posedge clk) disable iff (!rst_nq)
    launch_valid |-> tick_req);

  assert_reject_R11: assert property (@(posedge clk) disable iff (!rst_nq)
    (accept && req_write && ctrl_hit && zero_wg) |=> !launch_valid);

  for (genvar d = 0; d < 3; d++) begin : g_chk
    logic [PW2-1:0] hi_p, lo_p;
    assign hi_p = PW2'(cnt_w[d]) * PW2'(wg_f[d]);
    assign lo_p = hi_p - PW2'(wg_f[d]);
    // R6: count*size covers the grid, one fewer group would not
    assert_ceil_R6: assert property (@(posedge clk) disable iff (!rst_nq)
      launch_ok |-> (hi_p >= PW2'(grid_f[d])) &&
                    ((cnt_w[d] == '0) || (lo_p < PW2'(grid_f[d]))));
  end
endmodule

// File: tb/sim_kl_regwin.sv
`timescale 1ns/1ps
module sim_kl_regwin;
  localparam logic [31:0] BASE    = 32'h0000_4000;
  localparam int          RSP_LAT = 2;
  localparam int          QDEPTH  = 4;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         req_valid, req_write, pq_pop, tick_ack;
  logic [31:0]  req_addr;
  logic [1:0]   req_size;
  logic [63:0]  req_wdata;
  logic         req_ready, rsp_valid, rsp_err, launch_valid, pq_valid, tick_req;
  logic [63:0]  rsp_rdata;
  logic [7:0]   launch_id, pq_id;
  logic [15:0]  launch_wg_x, launch_wg_y, launch_wg_z;
  logic [47:0]  launch_wg_total;
  logic [255:0] launch_desc;

  always #2.5 clk = ~clk;

  kl_regwin #(.BASE(BASE), .RSP_LAT(RSP_LAT), .QDEPTH(QDEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_size(req_size),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .rsp_err(rsp_err), .launch_valid(launch_valid), .launch_id(launch_id),
    .launch_wg_x(launch_wg_x), .launch_wg_y(launch_wg_y), .launch_wg_z(launch_wg_z),
    .launch_wg_total(launch_wg_total), .launch_desc(launch_desc),
    .pq_valid(pq_valid), .pq_id(pq_id), .pq_pop(pq_pop),
    .tick_req(tick_req), .tick_ack(tick_ack)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // launch monitor, sampled away from the clock edge
  int           l_cnt = 0;
  logic [7:0]   l_id;
  logic [15:0]  l_x, l_y, l_z;
  logic [47:0]  l_tot;
  logic [255:0] l_desc;
  always @(negedge clk) begin
    if (rst_n && launch_valid) begin
      l_cnt++;
      l_id = launch_id; l_x = launch_wg_x; l_y = launch_wg_y; l_z = launch_wg_z;
      l_tot = launch_wg_total; l_desc = launch_desc;
    end
  end

  task automatic access(input logic wr, input logic [31:0] a, input logic [1:0] sz,
                        input logic [63:0] wd, output logic [63:0] rd, output logic er);
    int lat;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_size = sz; req_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!rsp_valid && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    rd = rsp_rdata;
    er = rsp_err;
    chk("R12 response latency", 64'(lat), 64'(RSP_LAT));
  endtask

  task automatic pop_expect(input logic [7:0] id);
    @(negedge clk);
    chk("R8 queue valid", 64'(pq_valid), 64'd1);
    chk("R8 queue head", 64'(pq_id), 64'(id));
    pq_pop = 1'b1;
    @(negedge clk);
    pq_pop = 1'b0;
  endtask

  typedef struct packed {
    logic        wr;
    logic [31:0] addr;
    logic [1:0]  sz;
    logic [63:0] wd;
    logic        err;
    logic [63:0] rd;
    logic [15:0] tag;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{1'b1, BASE + 32'd8,    2'd3, 64'h0010_0001_0003_0064, 1'b0, 64'h0, "R3"},
    '{1'b1, BASE + 32'd16,   2'd2, 64'h0000_0000_0001_0002, 1'b0, 64'h0, "R3"},
    '{1'b0, BASE + 32'd8,    2'd3, 64'h0, 1'b0, 64'h0010_0001_0003_0064, "R3"},
    '{1'b0, BASE + 32'd16,   2'd1, 64'h0, 1'b0, 64'h0002, "R3"},
    '{1'b0, BASE + 32'd17,   2'd0, 64'h0, 1'b0, 64'h00, "R3"},
    '{1'b0, BASE,            2'd3, 64'h0, 1'b0, 64'h0, "R2"},
    '{1'b0, BASE,            2'd2, 64'h0, 1'b1, 64'h0, "R2"},
    '{1'b0, BASE + 32'd4,    2'd3, 64'h0, 1'b1, 64'h0, "R4"},
    '{1'b1, BASE + 32'd3,    2'd0, 64'hFF, 1'b1, 64'h0, "R4"},
    '{1'b1, BASE + 32'd36,   2'd3, 64'h1111_2222_3333_4444, 1'b1, 64'h0, "R4"},
    '{1'b0, BASE + 32'd36,   2'd2, 64'h0, 1'b0, 64'h0, "R4"},
    '{1'b1, BASE + 32'd4096, 2'd0, 64'h77, 1'b1, 64'h0, "R1"},
    '{1'b0, BASE - 32'd8,    2'd3, 64'h0, 1'b1, 64'h0, "R1"},
    '{1'b1, BASE + 32'd39,   2'd0, 64'hAB, 1'b0, 64'h0, "R3"},
    '{1'b0, BASE + 32'd36,   2'd2, 64'h0, 1'b0, 64'hAB00_0000, "R3"},
    '{1'b0, BASE + 32'd38,   2'd2, 64'h0, 1'b1, 64'h0, "R4"}
  };

  initial begin
    #500000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [63:0] rd;
    logic        er;
    int          base_cnt;
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_size = '0;
    req_wdata = '0; pq_pop = 1'b0; tick_ack = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // reset state
    chk("R12 ready after reset", 64'(req_ready), 64'd1);
    chk("R5 no launch after reset", 64'(launch_valid), 64'd0);
    chk("R8 queue empty after reset", 64'(pq_valid), 64'd0);
    chk("R10 no tick after reset", 64'(tick_req), 64'd0);

    // table walk: decode, storage, boundaries
    for (int i = 0; i < NV; i++) begin
      access(VECS[i].wr, VECS[i].addr, VECS[i].sz, VECS[i].wd, rd, er);
      chk($sformatf("%s vec %0d err", VECS[i].tag, i), 64'(er), 64'(VECS[i].err));
      chk($sformatf("%s vec %0d data", VECS[i].tag, i), rd, VECS[i].rd);
    end
    chk("R4 rejected offset-0 neighbour did not launch", 64'(l_cnt), 64'd0);

    // first launch: grid 100x3x1, wg 16x2x1
    access(1'b1, BASE, 2'd3, 64'h0, rd, er);
    chk("R5 launch accepted", 64'(er), 64'd0);
    chk("R5 one launch pulse", 64'(l_cnt), 64'd1);
    chk("R7 first id", 64'(l_id), 64'd0);
    chk("R6 wg x", 64'(l_x), 64'd7);
    chk("R6 wg y", 64'(l_y), 64'd2);
    chk("R6 wg z", 64'(l_z), 64'd1);
    chk("R6 total", 64'(l_tot), 64'd14);
    chk("R5 descriptor copy", l_desc[63:0], 64'h0010_0001_0003_0064);
    chk("R5 descriptor last byte", 64'(l_desc[255:248]), 64'hAB);
    chk("R10 tick raised", 64'(tick_req), 64'd1);
    access(1'b0, BASE, 2'd3, 64'h0, rd, er);
    chk("R9 active after launch", rd, 64'd1);

    // second launch while tick still pending, byte-wide trigger
    access(1'b1, BASE, 2'd0, 64'h0, rd, er);
    chk("R7 second id", 64'(l_id), 64'd1);
    chk("R10 tick still single level", 64'(tick_req), 64'd1);
    @(negedge clk); tick_ack = 1'b1;
    @(negedge clk); tick_ack = 1'b0;
    chk("R10 tick cleared by ack", 64'(tick_req), 64'd0);

    // zero workgroup size rejects the launch
    access(1'b1, BASE + 32'd14, 2'd1, 64'h0, rd, er);
    access(1'b1, BASE, 2'd3, 64'h0, rd, er);
    chk("R11 zero wg size error", 64'(er), 64'd1);
    chk("R11 zero wg no launch", 64'(l_cnt), 64'd2);
    chk("R11 zero wg no tick", 64'(tick_req), 64'd0);

    // drain in order
    pop_expect(8'd0);
    pop_expect(8'd1);
    @(negedge clk);
    chk("R8 queue drained", 64'(pq_valid), 64'd0);
    access(1'b0, BASE, 2'd3, 64'h0, rd, er);
    chk("R9 inactive after drain", rd, 64'd0);

    // exact division: grid 64x3x1, wg 16x2x1
    access(1'b1, BASE + 32'd8, 2'd3, 64'h0010_0001_0003_0040, rd, er);
    access(1'b1, BASE, 2'd3, 64'h0, rd, er);
    chk("R7 id skips nothing after reject", 64'(l_id), 64'd2);
    chk("R6 exact x", 64'(l_x), 64'd4);
    chk("R6 exact total", 64'(l_tot), 64'd8);
    // zero grid in Y
    access(1'b1, BASE + 32'd10, 2'd1, 64'h0, rd, er);
    access(1'b1, BASE, 2'd3, 64'h0, rd, er);
    chk("R6 zero grid y", 64'(l_y), 64'd0);
    chk("R6 zero grid total", 64'(l_tot), 64'd0);
    chk("R7 fourth id", 64'(l_id), 64'd3);

    // fill the queue, then overflow attempt
    access(1'b1, BASE, 2'd3, 64'h0, rd, er);
    access(1'b1, BASE, 2'd3, 64'h0, rd, er);
    base_cnt = l_cnt;
    access(1'b1, BASE, 2'd3, 64'h0, rd, er);
    chk("R11 full queue error", 64'(er), 64'd1);
    chk("R11 full queue no launch", 64'(l_cnt), 64'(base_cnt));
    pop_expect(8'd2);
    pop_expect(8'd3);
    pop_expect(8'd4);
    pop_expect(8'd5);
    access(1'b1, BASE, 2'd3, 64'h0, rd, er);
    chk("R7 id after full reject", 64'(l_id), 64'd6);
    pop_expect(8'd6);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule